// File: doc/BRIEF.md
# ATM Receive Cell Output Formatter

This block sits at the end of a receive cell pipeline. Cells that have been checked upstream arrive one at a time as a 53-octet word. Each cell comes with its validation results: an uncorrectable header-check error, a corrected header error, a payload CRC error and a payload length error. The block decides whether to forward the cell. It then writes the chosen octets, one per cycle, to a byte-wide FIFO write port that has a valid/ready handshake.

Control inputs pick the output format: payload only, header plus payload with the header-check octet removed, the full cell, or an extended cell led by four prefix octets. In full-cell format a status octet can take the place of the header-check octet at the end of the cell. A header-only mode emits just the four header octets and the status octet. Disable bits let cells with individual error kinds through to the FIFO, but they do not silence the error-event pulses used for counting. A receiver-disable input silently consumes cells. One marker pin shows either the start of each cell on the FIFO port or a FIFO write-error input. All control inputs are sampled when a cell is accepted, so every change takes effect on a cell boundary.

Top module: `atm_rx_fmt`

## Requirements
- R1: With cfg_mode=00 (header-only and status off), a forwarded cell emits 48 octets: cell octets 5 to 52. Octet 0 of in_cell is in_cell[423:416].
- R2: With cfg_mode=01, a forwarded cell emits 52 octets: cell octets 0 to 3, then octets 5 to 52.
- R3: With cfg_mode=10 and cfg_status_en=0, a forwarded cell emits all 53 octets in order.
- R4: With cfg_mode=10 and cfg_status_en=1, a forwarded cell emits octets 0 to 3 and 5 to 52, then one status octet. The status octet is bit0 = in_hec_err, bit1 = in_hec_corr, bit2 = in_crc_err, bit3 = in_len_err, bits 7..4 = 0.
- R5: With cfg_mode=11, a forwarded cell emits 57 octets: the four in_prefix octets, most significant first, then cell octets 0 to 52.
- R6: With cfg_hdr_only=1, a forwarded cell emits octets 0 to 3 and then the R4 status octet, whatever cfg_mode says.
- R7: A cell is dropped if it has in_hec_err with cfg_dis_hec=0, or in_crc_err with cfg_dis_crc=0, or in_len_err with cfg_dis_len=0. A dropped cell makes no FIFO write and no start marker.
- R8: For each accepted cell while the receiver is enabled, ev_hec, ev_crc and ev_len each pulse for exactly one cycle, in the cycle after acceptance, when in_hec_err, in_crc_err or in_len_err is set. This happens whatever the disable bits and the drop decision are.
- R9: A cell accepted while cfg_rx_disable=1 is consumed with no FIFO write and no event pulse. A cell already being emitted when cfg_rx_disable rises is completed.
- R10: The format and enable inputs are sampled when a cell is accepted. Changing them during emission does not alter that cell.
- R11: While a cell is emitted, ctl_mark with cfg_marker_sel=1 is high exactly when the first octet of the cell is presented. With cfg_marker_sel=0, ctl_mark follows fifo_wr_err.
- R12: While fifo_valid is high and fifo_ready is low, fifo_valid and fifo_data hold. An octet advances only on fifo_valid and fifo_ready together.
- R13: in_ready is high exactly when no cell is being emitted, and a cell is accepted on in_valid and in_ready together. After reset, in_ready=1, fifo_valid=0 and the event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cell offered |
| in_ready | output | 1 | Block can accept a cell |
| in_cell | input | 424 | 53 cell octets, octet 0 in the top byte |
| in_prefix | input | 32 | Four prefix octets for the extended format |
| in_hec_err | input | 1 | Uncorrectable header-check error |
| in_hec_corr | input | 1 | Header error was corrected |
| in_crc_err | input | 1 | Payload CRC error |
| in_len_err | input | 1 | Payload length error |
| cfg_mode | input | 2 | Output format select |
| cfg_status_en | input | 1 | Status octet in full-cell format |
| cfg_hdr_only | input | 1 | Header-plus-status format |
| cfg_rx_disable | input | 1 | Consume cells silently |
| cfg_dis_hec | input | 1 | Forward cells with header-check errors |
| cfg_dis_crc | input | 1 | Forward cells with CRC errors |
| cfg_dis_len | input | 1 | Forward cells with length errors |
| cfg_marker_sel | input | 1 | 1: ctl_mark is start marker, 0: write-error |
| fifo_valid | output | 1 | Octet presented |
| fifo_ready | input | 1 | FIFO takes the octet |
| fifo_data | output | 8 | Octet |
| fifo_wr_err | input | 1 | FIFO write-error indication |
| ctl_mark | output | 1 | Start marker or write-error pin |
| ev_hec | output | 1 | Header-check error event pulse |
| ev_crc | output | 1 | CRC error event pulse |
| ev_len | output | 1 | Length error event pulse |

## Verification
The hardest situation to reach is a control change that lands while a cell is partly emitted. The bench has to catch the block between the first and last octet and alter both the receiver disable and the format there. It does this by waiting until the first octet has been taken under random FIFO backpressure, then flipping the inputs. It then checks that the current cell finishes in its original format, that the next cell vanishes without events, and that a later cell appears again. The main sweep covers every format against all sixteen flag combinations and all eight disable patterns.

// File: rtl/atm_rx_fmt_pkg.sv
package atm_rx_fmt_pkg;
  localparam int OCTET_W   = 8;
  localparam int CELL_N    = 53;
  localparam int PFX_N     = 4;
  localparam int EXT_N     = CELL_N + PFX_N;
  localparam int IDX_W     = $clog2(EXT_N + 1);
  localparam logic [IDX_W-1:0] SRC_STATUS = '1;

  typedef enum logic [2:0] {
    FMT_PAYLOAD, FMT_NOHEC, FMT_FULL, FMT_STATUS, FMT_EXT, FMT_HDR
  } fmt_e;

  function automatic fmt_e pick_fmt(input logic [1:0] mode, input logic status_en,
                                    input logic hdr_only);
    if (hdr_only) return FMT_HDR;
    case (mode)
      2'b00:   return FMT_PAYLOAD;
      2'b01:   return FMT_NOHEC;
      2'b10:   return status_en ? FMT_STATUS : FMT_FULL;
      default: return FMT_EXT;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] fmt_len(input fmt_e f);
    case (f)
      FMT_PAYLOAD: return IDX_W'(CELL_N - 5);
      FMT_NOHEC:   return IDX_W'(CELL_N - 1);
      FMT_FULL:    return IDX_W'(CELL_N);
      FMT_STATUS:  return IDX_W'(CELL_N);
      FMT_EXT:     return IDX_W'(EXT_N);
      default:     return IDX_W'(5);
    endcase
  endfunction

  // Output position k maps to an index into {prefix, cell}, or to the status slot.
  function automatic logic [IDX_W-1:0] src_index(input fmt_e f, input logic [IDX_W-1:0] k);
    logic [IDX_W-1:0] hdr_skip;
    hdr_skip = (k < 4) ? k + IDX_W'(PFX_N) : k + IDX_W'(PFX_N + 1);
    case (f)
      FMT_PAYLOAD: return k + IDX_W'(PFX_N + 5);
      FMT_NOHEC:   return hdr_skip;
      FMT_FULL:    return k + IDX_W'(PFX_N);
      FMT_STATUS:  return (k == IDX_W'(CELL_N - 1)) ? SRC_STATUS : hdr_skip;
      FMT_EXT:     return k;
      default:     return (k == IDX_W'(4)) ? SRC_STATUS : k + IDX_W'(PFX_N);
    endcase
  endfunction

  function automatic logic [OCTET_W-1:0] pack_status(input logic hec_err, input logic hec_corr,
                                                     input logic crc_err, input logic len_err);
    return {{(OCTET_W-4){1'b0}}, len_err, crc_err, hec_corr, hec_err};
  endfunction
endpackage

// File: rtl/atm_rx_fmt_gate.sv
module atm_rx_fmt_gate (
  input  logic       rx_en,
  input  logic       hec_err,
  input  logic       crc_err,
  input  logic       len_err,
  input  logic       dis_hec,
  input  logic       dis_crc,
  input  logic       dis_len,
  output logic       drop,
  output logic [2:0] ev_raw
);
  always_comb begin
    drop   = !rx_en || (hec_err && !dis_hec) || (crc_err && !dis_crc) || (len_err && !dis_len);
    ev_raw = rx_en ? {len_err, crc_err, hec_err} : 3'b000;
  end
endmodule

// File: rtl/atm_rx_fmt_ser.sv
module atm_rx_fmt_ser
  import atm_rx_fmt_pkg::*;
#(
  parameter int OCT_W = OCTET_W,
  parameter int EXT_W = EXT_N * OCT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXT_W-1:0] load_ext,
  input  logic [OCT_W-1:0] load_status,
  input  fmt_e             load_fmt,
  input  logic             fifo_ready,
  output logic             fifo_valid,
  output logic [OCT_W-1:0] fifo_data,
  output logic             first_octet,
  output logic             busy
);
  localparam int OCT_N = EXT_W / OCT_W;

  logic [EXT_W-1:0] ext_q;
  logic [OCT_W-1:0] status_q;
  fmt_e             fmt_q;
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;
  logic [IDX_W-1:0] src;
  logic             last_octet;

  always_comb begin
    src        = src_index(fmt_q, cnt_q);
    last_octet = (cnt_q == fmt_len(fmt_q) - IDX_W'(1));
    if (src == SRC_STATUS) fifo_data = status_q;
    else                   fifo_data = ext_q[(OCT_N - 1 - int'(src)) * OCT_W +: OCT_W];
  end

  assign fifo_valid  = busy_q;
  assign busy        = busy_q;
  assign first_octet = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      ext_q    <= '0;
      status_q <= '0;
      fmt_q    <= FMT_PAYLOAD;
    end else if (load) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      ext_q    <= load_ext;
      status_q <= load_status;
      fmt_q    <= load_fmt;
    end else if (busy_q && fifo_ready) begin
      if (last_octet) busy_q <= 1'b0;
      else            cnt_q  <= cnt_q + IDX_W'(1);
    end
  end

  // R12
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data));

  // R12
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q < fmt_len(fmt_q));
endmodule

// File: rtl/atm_rx_fmt.sv
module atm_rx_fmt
  import atm_rx_fmt_pkg::*;
#(
  parameter int OCT_W  = OCTET_W,
  parameter int CELL_W = CELL_N * OCT_W,
  parameter int PFX_W  = PFX_N * OCT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CELL_W-1:0] in_cell,
  input  logic [PFX_W-1:0]  in_prefix,
  input  logic              in_hec_err,
  input  logic              in_hec_corr,
  input  logic              in_crc_err,
  input  logic              in_len_err,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_status_en,
  input  logic              cfg_hdr_only,
  input  logic              cfg_rx_disable,
  input  logic              cfg_dis_hec,
  input  logic              cfg_dis_crc,
  input  logic              cfg_dis_len,
  input  logic              cfg_marker_sel,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [OCT_W-1:0]  fifo_data,
  input  logic              fifo_wr_err,
  output logic              ctl_mark,
  output logic              ev_hec,
  output logic              ev_crc,
  output logic              ev_len
);
  logic       busy;
  logic       first_octet;
  logic       accept;
  logic       drop;
  logic       keep;
  logic [2:0] ev_raw;
  logic [2:0] ev_q;
  logic       sel_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign keep     = accept && !drop;

  atm_rx_fmt_gate gate_i (
    .rx_en   (!cfg_rx_disable),
    .hec_err (in_hec_err),
    .crc_err (in_crc_err),
    .len_err (in_len_err),
    .dis_hec (cfg_dis_hec),
    .dis_crc (cfg_dis_crc),
    .dis_len (cfg_dis_len),
    .drop    (drop),
    .ev_raw  (ev_raw)
  );

  atm_rx_fmt_ser #(.OCT_W(OCT_W), .EXT_W(CELL_W + PFX_W)) ser_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (keep),
    .load_ext    ({in_prefix, in_cell}),
    .load_status (pack_status(in_hec_err, in_hec_corr, in_crc_err, in_len_err)),
    .load_fmt    (pick_fmt(cfg_mode, cfg_status_en, cfg_hdr_only)),
    .fifo_ready  (fifo_ready),
    .fifo_valid  (fifo_valid),
    .fifo_data   (fifo_data),
    .first_octet (first_octet),
    .busy        (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      ev_q <= accept ? ev_raw : 3'b000;
      if (accept) sel_q <= cfg_marker_sel;
    end
  end

  assign {ev_len, ev_crc, ev_hec} = ev_q;
  assign ctl_mark = sel_q ? first_octet : fifo_wr_err;

  // R7
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && drop |=> !fifo_valid);

  // R8
  ev_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hec || ev_crc || ev_len) |-> $past(accept));

  // R13
  start_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> fifo_valid && first_octet && !in_ready);

  // R11
  mark_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q && ctl_mark |-> fifo_valid);
endmodule

// File: tb/atm_rx_fmt_tb_top.sv
module atm_rx_fmt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0, in_ready;
  logic [423:0] in_cell = '0;
  logic [31:0]  in_prefix = '0;
  logic in_hec_err = 0, in_hec_corr = 0, in_crc_err = 0, in_len_err = 0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_status_en = 0, cfg_hdr_only = 0, cfg_rx_disable = 0;
  logic cfg_dis_hec = 0, cfg_dis_crc = 0, cfg_dis_len = 0, cfg_marker_sel = 0;
  logic fifo_valid, fifo_ready = 1'b0, fifo_wr_err = 1'b0, ctl_mark;
  logic [7:0] fifo_data;
  logic ev_hec, ev_crc, ev_len;

  atm_rx_fmt dut_i (.*);

  int errors = 0, checks = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int ev_cnt[3];
  int mark_bad = 0, hold_bad = 0;
  logic [7:0] lfsr = 8'hA5;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic [7:0] cb[53];
  logic [7:0] pf[4];

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: drives ready and wr_err at the falling edge, then samples.
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      fifo_ready  = (lfsr[1:0] != 2'b00);
      fifo_wr_err = lfsr[3];
      #1;
      if (rst_n) begin
        if (prev_stall && (!fifo_valid || fifo_data != prev_data)) hold_bad++;
        if (fifo_valid) begin
          if (cfg_marker_sel ? (ctl_mark != (got_q.size() == 0)) : (ctl_mark != fifo_wr_err))
            mark_bad++;
        end
        if (fifo_valid && fifo_ready) got_q.push_back(fifo_data);
        prev_stall = fifo_valid && !fifo_ready;
        prev_data  = fifo_data;
        if (ev_hec) ev_cnt[0]++;
        if (ev_crc) ev_cnt[1]++;
        if (ev_len) ev_cnt[2]++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic make_cell(input int seed);
    for (int i = 0; i < 53; i++) begin
      cb[i] = 8'((seed * 37) + i * 11 + (i >> 2));
      in_cell[(52 - i) * 8 +: 8] = cb[i];
    end
    for (int i = 0; i < 4; i++) begin
      pf[i] = 8'(8'hC0 + seed + i * 3);
      in_prefix[(3 - i) * 8 +: 8] = pf[i];
    end
  endtask

  // f: 0 pay, 1 no-hec, 2 full, 3 full+status, 4 extended, 5 header-only
  task automatic build_exp(input int f, input logic [3:0] fl);
    logic [7:0] st;
    st = {4'b0000, fl};
    exp_q.delete();
    case (f)
      0: for (int i = 5; i < 53; i++) exp_q.push_back(cb[i]);
      1: for (int i = 0; i < 53; i++) if (i != 4) exp_q.push_back(cb[i]);
      2: for (int i = 0; i < 53; i++) exp_q.push_back(cb[i]);
      3: begin
        for (int i = 0; i < 53; i++) if (i != 4) exp_q.push_back(cb[i]);
        exp_q.push_back(st);
      end
      4: begin
        for (int i = 0; i < 4; i++) exp_q.push_back(pf[i]);
        for (int i = 0; i < 53; i++) exp_q.push_back(cb[i]);
      end
      default: begin
        for (int i = 0; i < 4; i++) exp_q.push_back(cb[i]);
        exp_q.push_back(st);
      end
    endcase
  endtask

  task automatic set_fmt(input int f, input logic [1:0] junk_mode);
    cfg_status_en = (f == 3) || (f == 5);
    cfg_hdr_only  = (f == 5);
    case (f)
      0: cfg_mode = 2'b00;
      1: cfg_mode = 2'b01;
      2, 3: cfg_mode = 2'b10;
      4: cfg_mode = 2'b11;
      default: cfg_mode = junk_mode;
    endcase
  endtask

  task automatic send();
    got_q.delete();
    ev_cnt = '{0, 0, 0};
    mark_bad = 0;
    hold_bad = 0;
    @(negedge clk);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    bit ok;
    int bad;
    ok = (got_q.size() == exp_q.size());
    bad = -1;
    if (ok) foreach (exp_q[i]) if (got_q[i] !== exp_q[i] && bad < 0) bad = i;
    if (!ok) check(req, 0, got_q.size(), exp_q.size());
    else if (bad >= 0) check(req, 0, got_q[bad], exp_q[bad]);
    else check(req, 1, 0, 0);
  endtask

  task automatic cmp_events(input string req, input logic [2:0] want);
    int a, e;
    a = ev_cnt[0] + ev_cnt[1] * 4 + ev_cnt[2] * 16;
    e = want[0] + want[1] * 4 + want[2] * 16;
    check(req, a == e, a, e);
  endtask

  initial begin
    string tag;
    logic [3:0] fl;
    logic [2:0] d;
    bit dropped;
    int n = 0;
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 in_ready at reset", in_ready == 1'b1, in_ready, 1);
    check("R13 fifo_valid at reset", fifo_valid == 1'b0, fifo_valid, 0);
    check("R13 events at reset", {ev_hec, ev_crc, ev_len} == 3'b000, {ev_hec, ev_crc, ev_len}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 6; f++) begin
      for (int fi = 0; fi < 16; fi++) begin
        for (int di = 0; di < 8; di++) begin
          fl = 4'(fi);
          d  = 3'(di);
          n++;
          make_cell(n);
          set_fmt(f, 2'(fi));
          {in_len_err, in_crc_err, in_hec_corr, in_hec_err} = fl;
          {cfg_dis_len, cfg_dis_crc, cfg_dis_hec} = d;
          cfg_marker_sel = n[0];
          cfg_rx_disable = 1'b0;
          dropped = (fl[0] && !d[0]) || (fl[2] && !d[1]) || (fl[3] && !d[2]);
          if (dropped) exp_q.delete();
          else build_exp(f, fl);
          send();
          drain();
          case (f)
            0: tag = "R1 payload-only";
            1: tag = "R2 no-hec";
            2: tag = "R3 full";
            3: tag = "R4 status";
            4: tag = "R5 extended";
            default: tag = "R6 header-only";
          endcase
          if (dropped) tag = "R7 drop";
          cmp_stream(tag);
          // R8: one pulse per flagged error, disables ignored
          cmp_events("R8 events", {fl[3], fl[2], fl[0]});
          check("R11 marker", mark_bad == 0, mark_bad, 0);
          check("R12 hold under stall", hold_bad == 0, hold_bad, 0);
        end
      end
    end

    // R9 / R10: control changes in the middle of a cell
    n++;
    make_cell(n);
    set_fmt(1, 2'b00);
    {in_len_err, in_crc_err, in_hec_corr, in_hec_err} = 4'b0000;
    {cfg_dis_len, cfg_dis_crc, cfg_dis_hec} = 3'b000;
    cfg_marker_sel = 1'b1;
    build_exp(1, 4'b0000);
    send();
    while (got_q.size() < 1) @(negedge clk);
    cfg_rx_disable = 1'b1;
    cfg_mode = 2'b00;
    cfg_marker_sel = 1'b0;
    cfg_marker_sel = 1'b1;
    drain();
    cmp_stream("R10 mid-cell change keeps format");
    check("R9 cell in progress completes", got_q.size() == 52, got_q.size(), 52);

    n++;
    make_cell(n);
    {in_len_err, in_crc_err, in_hec_corr, in_hec_err} = 4'b1101;
    exp_q.delete();
    send();
    drain();
    cmp_stream("R9 disabled cell silent");
    cmp_events("R9 disabled no events", 3'b000);

    cfg_rx_disable = 1'b0;
    n++;
    make_cell(n);
    {in_len_err, in_crc_err, in_hec_corr, in_hec_err} = 4'b0000;
    set_fmt(0, 2'b00);
    build_exp(0, 4'b0000);
    send();
    drain();
    cmp_stream("R9 re-enabled forwards");
    check("R13 idle after cell", in_ready == 1'b1 && fifo_valid == 1'b0, fifo_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule